// File: doc/BRIEF.md
# Paired-Byte Flash Word Programmer with Page Erase

This block sits between a processor's register interface and an on-chip flash array. The array is modelled here as a behavioural memory of 16-bit words. Software loads a word address as two byte registers (high and low) and a clock prescaler setting. It then raises a write request and streams data bytes over a valid/ready port. Every two accepted bytes form one word. That word is programmed into the current address, and the address then steps up by one for the next pair.

The next pair must begin and complete within a timeout after the controller becomes ready again. If it does not, the burst is abandoned and a sticky abort flag is raised. A single pulse erases the whole page that holds the loaded address. If an erase pulse and a rising write request arrive together, the erase runs to completion and the write burst follows it.

Data-port rules:
- A byte moves only on a cycle where both `wdata_valid` and `wdata_ready` are high.
- `wdata_ready` is low while a word is being programmed and while an erase is running. The source must hold its byte until it is accepted.
- With no operation running, `wdata_ready` is high and accepted bytes are thrown away.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `busy`, `sw_busy` and `abort_flag` are 0, `wdata_ready` is 1, and every array word reads 0xFFFF.
- R2: In a write burst, the first accepted byte becomes bits [7:0] of the word and the second becomes bits [15:8]. The word is programmed only after the second byte is accepted.
- R3: A burst begins at word address {addr_hi,addr_lo} (low AW bits), taken on the rising edge of `write_req`. After each programmed word the address increases by one.
- R4: Programming only clears bits: the new word is the old word AND the written data.
- R5: From the cycle after the second byte of a pair is accepted, `sw_busy` is 1 and `wdata_ready` is 0 until the word is done.
- R6: A word takes PROG_TICKS*(time_div+1) cycles of `sw_busy`. A page erase keeps `busy` high for ERASE_TICKS*(time_div+1) cycles.
- R7: If `write_req` is still high and no full pair arrives within TIMEOUT_CYCLES cycles of entering the wait for data, the burst ends and `abort_flag` becomes 1. No further word is written.
- R8: `abort_flag` stays set until a new erase or write is started from idle, which clears it.
- R9: An `erase_req` pulse sets every word of the page holding the loaded address to 0xFFFF. The page is the address divided by PAGE_WORDS. Other pages are unchanged.
- R10: With `erase_req` and a rising `write_req` in the same cycle, the erase completes first and the burst then runs at the same address. `wdata_ready` is 0 during the erase.
- R11: Bytes accepted while idle are discarded and are never paired with later burst data.
- R12: `busy` is 1 throughout a burst, including between pairs. Dropping `write_req` while waiting for data ends the burst without abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| write_req | input | 1 | Write control level; its rising edge starts a burst, its fall ends one |
| erase_req | input | 1 | One-cycle page erase start |
| addr_hi | input | 8 | Word address, high byte |
| addr_lo | input | 8 | Word address, low byte |
| time_div | input | DIV_W | Prescaler: one timing tick per time_div+1 cycles |
| wdata_valid | input | 1 | Data byte valid |
| wdata_ready | output | 1 | Controller accepts a byte |
| wdata | input | DATA_W | Data byte |
| busy | output | 1 | Burst or erase in progress |
| sw_busy | output | 1 | Current word being programmed |
| abort_flag | output | 1 | Sticky write-timeout status |
| rd_addr | input | AW | Array read address |
| rd_data | output | 2*DATA_W | Array read word (combinational) |

## Verification
A wrong pairing or address state shows up as a wrong word at the read port as soon as the burst's word has been programmed. Wrong phase timing shows up as a wrong count of `sw_busy` or `busy` cycles. A stuck or early timeout is seen as `busy` falling at the wrong moment, a wrongly set `abort_flag`, or a missing word. Erase ordering is caught by data written just before an erase-plus-write, which then reads back unmasked.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PROG  = 2'd3
  } fp_state_e;
endpackage

// File: rtl/flash_tick_gen.sv
module flash_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || tick)  cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/flash_pair_collect.sv
module flash_pair_collect #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                collect,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_byte,
  output logic                have_lo,
  output logic                pair_fire,
  output logic [2*DATA_W-1:0] pair_word
);
  logic [DATA_W-1:0] lo_q;
  logic              take_lo;

  assign take_lo   = collect && in_valid && !have_lo;
  assign pair_fire = collect && in_valid && have_lo;
  assign pair_word = {in_byte, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_lo <= 1'b0;
      lo_q    <= '0;
    end else if (!collect) begin
      have_lo <= 1'b0;
    end else if (take_lo) begin
      lo_q    <= in_byte;
      have_lo <= 1'b1;
    end else if (pair_fire) begin
      have_lo <= 1'b0;
    end
  end

  // R2
  pair_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> !have_lo);
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int WORDS      = 128,
  parameter int PAGE_WORDS = 16,
  parameter int WORD_W     = 16,
  localparam int AW        = $clog2(WORDS),
  localparam int PW_L      = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              er_en,
  input  logic [AW-PW_L-1:0] er_page,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [WORDS];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (er_en) begin
        for (int i = 0; i < WORDS; i++)
          if ((i / PAGE_WORDS) == int'(er_page)) mem[i] <= '1;
      end
      if (wr_en) mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  // R4
  and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !er_en) |=> ((mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == '0));

  // R9
  erase_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && er_en));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int WORDS          = 128,
  parameter int PAGE_WORDS     = 16,
  parameter int DATA_W         = 8,
  parameter int DIV_W          = 8,
  parameter int PROG_TICKS     = 4,
  parameter int ERASE_TICKS    = 30,
  parameter int TIMEOUT_CYCLES = 40,
  localparam int WORD_W        = 2 * DATA_W,
  localparam int AW            = $clog2(WORDS),
  localparam int PW_L          = $clog2(PAGE_WORDS),
  localparam int MAX_TICKS     = (ERASE_TICKS > PROG_TICKS) ? ERASE_TICKS : PROG_TICKS,
  localparam int TK_W          = $clog2(MAX_TICKS + 1),
  localparam int TO_W          = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              write_req,
  input  logic              erase_req,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        addr_lo,
  input  logic [DIV_W-1:0]  time_div,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              sw_busy,
  output logic              abort_flag,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  fp_state_e         state_q, state_d;
  logic [AW-1:0]     waddr_q;
  logic [WORD_W-1:0] word_q;
  logic              wr_pend_q, wreq_q, abort_q;
  logic [TK_W-1:0]   tick_cnt_q;
  logic [TO_W-1:0]   to_cnt_q;

  logic              tick, state_chg, wr_rise, start_any;
  logic              phase_done, timeout, timeout_evt;
  logic [TK_W-1:0]   phase_lim;
  logic              have_lo, pair_fire;
  logic [WORD_W-1:0] pair_word;
  logic [15:0]       addr_full;
  logic              addr_unused;

  assign addr_full   = {addr_hi, addr_lo};
  assign addr_unused = ^(addr_full >> AW);

  assign wr_rise   = write_req && !wreq_q;
  assign start_any = (state_q == ST_IDLE) && (erase_req || wr_rise);
  assign phase_lim = (state_q == ST_ERASE) ? TK_W'(ERASE_TICKS - 1) : TK_W'(PROG_TICKS - 1);
  assign phase_done = tick && (tick_cnt_q == phase_lim);
  assign timeout   = (to_cnt_q == TO_W'(TIMEOUT_CYCLES - 1));

  flash_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(state_chg), .div(time_div), .tick(tick)
  );

  flash_pair_collect #(.DATA_W(DATA_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .collect(state_q == ST_WAIT),
    .in_valid(wdata_valid), .in_byte(wdata),
    .have_lo(have_lo), .pair_fire(pair_fire), .pair_word(pair_word)
  );

  flash_array_model #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en((state_q == ST_PROG) && phase_done), .wr_addr(waddr_q), .wr_data(word_q),
    .er_en((state_q == ST_ERASE) && phase_done), .er_page(waddr_q[AW-1:PW_L]),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_comb begin
    state_d     = state_q;
    timeout_evt = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (erase_req)    state_d = ST_ERASE;
        else if (wr_rise) state_d = ST_WAIT;
      end
      ST_ERASE: begin
        if (phase_done) state_d = wr_pend_q ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        if (pair_fire)       state_d = ST_PROG;
        else if (!write_req) state_d = ST_IDLE;
        else if (timeout) begin
          state_d     = ST_IDLE;
          timeout_evt = 1'b1;
        end
      end
      ST_PROG: begin
        if (phase_done) state_d = ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_chg = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      waddr_q    <= '0;
      word_q     <= '0;
      wr_pend_q  <= 1'b0;
      wreq_q     <= 1'b0;
      abort_q    <= 1'b0;
      tick_cnt_q <= '0;
      to_cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      wreq_q  <= write_req;
      if (start_any) begin
        waddr_q   <= addr_full[AW-1:0];
        wr_pend_q <= erase_req && wr_rise;
        abort_q   <= 1'b0;
      end else if (timeout_evt) begin
        abort_q <= 1'b1;
      end
      if (pair_fire && state_q == ST_WAIT) word_q <= pair_word;
      if (state_q == ST_PROG && phase_done) waddr_q <= waddr_q + 1'b1;
      if (state_chg)  tick_cnt_q <= '0;
      else if (tick)  tick_cnt_q <= tick_cnt_q + 1'b1;
      if (state_chg || state_q != ST_WAIT) to_cnt_q <= '0;
      else                                 to_cnt_q <= to_cnt_q + 1'b1;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign sw_busy     = (state_q == ST_PROG);
  assign wdata_ready = (state_q == ST_IDLE) || (state_q == ST_WAIT);
  assign abort_flag  = abort_q;

  // R5
  pair_to_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && wdata_valid && wdata_ready && have_lo) |=> (sw_busy && !wdata_ready));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_busy && phase_done) |=> (waddr_q == $past(waddr_q) + 1'b1));

  // R7
  timeout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && write_req && !pair_fire && timeout) |=> (abort_flag && !busy));

  // R8
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !start_any) |=> abort_flag);

  // R10
  erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && phase_done && wr_pend_q) |=> (state_q == ST_WAIT));
endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_T = 4;
  localparam int ERASE_T = 30;
  localparam int TO_C = 40;

  logic clk = 0, rst_n = 0;
  logic write_req = 0, erase_req = 0;
  logic [7:0] addr_hi = 0, addr_lo = 0;
  logic [7:0] time_div = 0;
  logic wdata_valid = 0, wdata_ready;
  logic [7:0] wdata = 0;
  logic busy, sw_busy, abort_flag;
  logic [6:0] rd_addr = 0;
  logic [15:0] rd_data;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_ctrl #(.PROG_TICKS(PROG_T), .ERASE_TICKS(ERASE_T), .TIMEOUT_CYCLES(TO_C)) u_dut (
    .clk(clk), .rst_n(rst_n), .write_req(write_req), .erase_req(erase_req),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .time_div(time_div),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .busy(busy), .sw_busy(sw_busy), .abort_flag(abort_flag),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[6:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    wdata_valid = 1; wdata = b;
    while (!wdata_ready) @(negedge clk);
    @(negedge clk);
    wdata_valid = 0;
  endtask

  task automatic send_pair(input logic [15:0] w);
    send_byte(w[7:0]);
    send_byte(w[15:8]);
  endtask

  task automatic wait_swb_low();
    while (sw_busy) @(negedge clk);
  endtask

  task automatic start_burst(input int a);
    @(negedge clk);
    addr_hi = 8'(a >> 8); addr_lo = 8'(a); write_req = 1;
  endtask

  task automatic end_burst();
    @(negedge clk); write_req = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 busy", busy, 0);
    chk("R1 sw_busy", sw_busy, 0);
    chk("R1 abort", abort_flag, 0);
    chk("R1 ready", wdata_ready, 1);
    rd(0, v);   chk("R1 word0", v, 16'hFFFF);
    rd(127, v); chk("R1 word127", v, 16'hFFFF);
  endtask

  task automatic t_idle_ignore();
    int v;
    send_byte(8'h11);
    chk("R11 idle busy", busy, 0);
    start_burst(5);
    send_pair(16'h1234);
    wait_swb_low();
    end_burst();
    rd(5, v); chk("R11 stray byte dropped", v, 16'h1234);
  endtask

  task automatic t_burst();
    int v;
    int bad = 0;
    start_burst(32);
    send_pair(16'hA1B2); wait_swb_low();
    if (!busy) bad++;
    send_pair(16'hC3D4); wait_swb_low();
    if (!busy) bad++;
    send_pair(16'hE5F6); wait_swb_low();
    chk("R12 busy between pairs", bad, 0);
    end_burst();
    chk("R12 clean end busy", busy, 0);
    chk("R12 clean end abort", abort_flag, 0);
    rd(32, v); chk("R2 word n", v, 16'hA1B2);
    rd(33, v); chk("R3 word n+1", v, 16'hC3D4);
    rd(34, v); chk("R3 word n+2", v, 16'hE5F6);
    rd(35, v); chk("R3 word n+3 untouched", v, 16'hFFFF);
  endtask

  task automatic prog_count(input int div, input int a, input logic [15:0] w);
    int cnt = 0;
    int rdy_bad = 0;
    time_div = 8'(div);
    start_burst(a);
    send_byte(w[7:0]);
    send_byte(w[15:8]);
    while (sw_busy) begin
      cnt++;
      if (wdata_ready) rdy_bad++;
      @(negedge clk);
    end
    chk("R6 prog cycles", cnt, PROG_T * (div + 1));
    chk("R5 ready low while programming", rdy_bad, 0);
    end_burst();
  endtask

  task automatic t_prog_time();
    prog_count(0, 40, 16'h5555);
    prog_count(2, 41, 16'h6666);
    time_div = 0;
  endtask

  task automatic t_and();
    int v;
    start_burst(32);
    send_pair(16'h0F0F); wait_swb_low();
    end_burst();
    rd(32, v); chk("R4 and-only write", v, 16'hA1B2 & 16'h0F0F);
  endtask

  task automatic t_timeout();
    int v;
    int cnt = 0;
    start_burst(60);
    send_pair(16'h7788); wait_swb_low();
    while (busy && cnt < 200) begin cnt++; @(negedge clk); end
    chk("R7 burst ended", busy, 0);
    chk("R7 abort set", abort_flag, 1);
    chk("R7 timeout window", cnt, TO_C);
    @(negedge clk); write_req = 0;
    repeat (10) @(negedge clk);
    chk("R8 abort sticky", abort_flag, 1);
    rd(60, v); chk("R7 word before timeout", v, 16'h7788);
    rd(61, v); chk("R7 no word after timeout", v, 16'hFFFF);
  endtask

  task automatic t_erase();
    int v;
    int cnt = 0;
    time_div = 1;
    @(negedge clk);
    addr_hi = 0; addr_lo = 8'd35; erase_req = 1;
    @(negedge clk); erase_req = 0;
    chk("R8 abort cleared by start", abort_flag, 0);
    while (busy && cnt < 500) begin cnt++; @(negedge clk); end
    chk("R6 erase cycles", cnt, ERASE_T * 2);
    rd(32, v); chk("R9 page word 32 erased", v, 16'hFFFF);
    rd(34, v); chk("R9 page word 34 erased", v, 16'hFFFF);
    rd(41, v); chk("R9 page word 41 erased", v, 16'hFFFF);
    rd(5, v);  chk("R9 other page kept", v, 16'h1234);
    rd(60, v); chk("R9 other page kept 60", v, 16'h7788);
    time_div = 0;
  endtask

  task automatic t_erase_write();
    int v;
    start_burst(80);
    send_pair(16'h00FF); wait_swb_low();
    end_burst();
    @(negedge clk);
    addr_hi = 0; addr_lo = 8'd80; erase_req = 1; write_req = 1;
    @(negedge clk); erase_req = 0;
    repeat (5) @(negedge clk);
    chk("R10 busy in erase", busy, 1);
    chk("R10 ready low in erase", wdata_ready, 0);
    chk("R10 no sw_busy in erase", sw_busy, 0);
    send_pair(16'hAA55); wait_swb_low();
    end_burst();
    rd(80, v); chk("R10 erase before write", v, 16'hAA55);
    rd(81, v); chk("R10 next word", v, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_burst();
    t_prog_time();
    t_and();
    t_timeout();
    t_erase();
    t_erase_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule